// File: doc/BRIEF.md
# Two-Word Instruction Prefetch Queue

This block sits between instruction memory and an instruction decoder. It holds exactly two 16-bit words ahead of execution. The first is the decode word, the one the decoder is looking at now. The second is the next word of the stream. Opcodes and extension words both enter through the same fetch path. Each time the decoder takes a word, the queue shifts, and one new fetch is issued at the running fetch pointer.

A redirect supplies a new target address. It empties the queue and reloads the fetch pointer. The ready flag stays low until both words from the target have arrived.

Stores to memory are not checked against the queue. A word already fetched keeps the value it had when it was read. A later store to that address only matters if the word has not been fetched yet. A fetch that completes in the same cycle as a redirect is dropped.

Top module: `prefetch_queue`

## Requirements
- R1: During and right after reset, `ready` is 0, `mem_req` is 1 and `mem_addr` equals the `RESET_ADDR` parameter (default 16'h0100).
- R2: After reset, the queue loads the words at `RESET_ADDR` and `RESET_ADDR+2`. Once both are held, `ready` is 1. `ir_word` is then the first word and `ext_word` the second.
- R3: `mem_addr` is a byte address. It advances by exactly 2 for every fetch accepted (a cycle with `mem_req` and `mem_ack` both high and no redirect).
- R4: A `take` pulse while `ready` is 1 consumes the decode word. On the next cycle `ir_word` holds the former `ext_word`, `ready` is 0, and exactly one refill is requested at the next sequential address.
- R5: A `take` pulse while `ready` is 0 has no effect: the decode word and the position in the stream are unchanged.
- R6: A `redirect` pulse empties the queue. On the next cycle `ready` is 0 and `mem_addr` equals `redirect_addr`. `ready` returns only when the words at the target and target+2 are held, in that order.
- R7: A fetch acknowledged in the same cycle as a `redirect` is discarded and never appears in the queue.
- R8: A word already held in the queue is not changed by a later memory write to its address. Words fetched after such a write carry the written value.
- R9: While `mem_req` is high and no acknowledge or redirect occurs, `mem_req` stays high and `mem_addr` stays stable on the next cycle.
- R10: `mem_req` is 0 whenever both queue words are held (`ready` is 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_req | output | 1 | Fetch request, held until acknowledged |
| mem_addr | output | AW | Byte address of the requested word |
| mem_ack | input | 1 | Fetch completes this cycle; `mem_rdata` is valid |
| mem_rdata | input | 16 | Fetched instruction word |
| take | input | 1 | Decoder consumes the decode word |
| redirect | input | 1 | Change of flow: flush and load the target |
| redirect_addr | input | AW | Byte address of the change-of-flow target |
| ready | output | 1 | Both queue words are held |
| ir_word | output | 16 | Decode word |
| ext_word | output | 16 | Queued word following the decode word |

## Verification
If the slot contents or the fill order go wrong, the next `ready` rise shows `ir_word` or `ext_word` values that differ from the memory model at the tracked program address. Each scenario checks those values one refill after its stimulus.

A wrong fetch pointer shows on `mem_addr` in the cycle after an accepted fetch or a redirect. A wrong fill count shows as `ready` rising early, rising late, or never rising, which the bench detects within a bounded wait.

A dropped discard after a redirect shows as a stale word in the decode slot at the target. Snooping that should not happen shows as a rewritten value in a word that had already been fetched.

// File: rtl/pfq_pkg.sv
`timescale 1ns/1ps
package pfq_pkg;
    localparam int WORD_W     = 16;
    localparam int QDEPTH     = 2;
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int LVL_W      = $clog2(QDEPTH + 1);

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic  valid;
        word_t data;
    } slot_t;

    localparam slot_t EMPTY_SLOT = '{valid: 1'b0, data: '0};

    function automatic logic [LVL_W-1:0] count_valid(input slot_t s [QDEPTH]);
        logic [LVL_W-1:0] n;
        n = '0;
        for (int i = 0; i < QDEPTH; i++) n = n + LVL_W'(s[i].valid);
        return n;
    endfunction
endpackage

// File: rtl/pfq_fetch_ptr.sv
`timescale 1ns/1ps
module pfq_fetch_ptr
    import pfq_pkg::*;
#(
    parameter int AW = 16,
    parameter logic [AW-1:0] RESET_ADDR = 16'h0100
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] target,
    input  logic          advance,
    output logic [AW-1:0] ptr
);
    localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

    always_ff @(posedge clk) begin
        if (rst)          ptr <= RESET_ADDR;
        else if (load)    ptr <= target;
        else if (advance) ptr <= ptr + STEP;
    end
endmodule

// File: rtl/pfq_slots.sv
`timescale 1ns/1ps
module pfq_slots
    import pfq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             pop,
    input  logic             fill,
    input  word_t            fill_data,
    output word_t            head,
    output word_t            second,
    output logic [LVL_W-1:0] level
);
    slot_t slot_q [QDEPTH];
    slot_t slot_d [QDEPTH];

    always_comb begin
        for (int i = 0; i < QDEPTH; i++) begin
            int up;
            int dn;
            logic prev_full;
            up = (i + 1 < QDEPTH) ? i + 1 : i;
            dn = (i > 0) ? i - 1 : 0;
            prev_full = (i == 0) ? 1'b1 : slot_q[dn].valid;
            slot_d[i] = slot_q[i];
            if (flush) begin
                slot_d[i].valid = 1'b0;
            end else if (pop) begin
                slot_d[i] = (i + 1 < QDEPTH) ? slot_q[up] : EMPTY_SLOT;
            end else if (fill && !slot_q[i].valid && prev_full) begin
                slot_d[i].valid = 1'b1;
                slot_d[i].data  = fill_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < QDEPTH; i++) begin
            if (rst) slot_q[i] <= EMPTY_SLOT;
            else     slot_q[i] <= slot_d[i];
        end
    end

    assign head   = slot_q[0].data;
    assign second = slot_q[1].data;
    assign level  = count_valid(slot_q);
endmodule

// File: rtl/prefetch_queue.sv
`timescale 1ns/1ps
module prefetch_queue
    import pfq_pkg::*;
#(
    parameter int AW = 16,
    parameter logic [AW-1:0] RESET_ADDR = 16'h0100
) (
    input  logic              clk,
    input  logic              rst,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              take,
    input  logic              redirect,
    input  logic [AW-1:0]     redirect_addr,
    output logic              ready,
    output logic [WORD_W-1:0] ir_word,
    output logic [WORD_W-1:0] ext_word
);
    logic [LVL_W-1:0] level;
    logic accept;
    logic pop;

    // the redirect wins over a completing fetch and over a consume
    assign mem_req = (level < LVL_W'(QDEPTH));
    assign ready   = (level == LVL_W'(QDEPTH));
    assign accept  = mem_req && mem_ack && !redirect;
    assign pop     = take && ready && !redirect;

    pfq_fetch_ptr #(.AW(AW), .RESET_ADDR(RESET_ADDR)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .load    (redirect),
        .target  (redirect_addr),
        .advance (accept),
        .ptr     (mem_addr)
    );

    pfq_slots u_slots (
        .clk       (clk),
        .rst       (rst),
        .flush     (redirect),
        .pop       (pop),
        .fill      (accept),
        .fill_data (mem_rdata),
        .head      (ir_word),
        .second    (ext_word),
        .level     (level)
    );
endmodule

// File: rtl/pfq_checker.sv
`timescale 1ns/1ps
module pfq_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          mem_req,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ack,
    input logic          take,
    input logic          redirect,
    input logic [AW-1:0] redirect_addr,
    input logic          ready,
    input logic [15:0]   ir_word,
    input logic [15:0]   ext_word
);
    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_ack && !redirect |=> mem_addr == $past(mem_addr) + AW'(2));

    // R4
    consume_shift_chk: assert property (@(posedge clk) disable iff (rst)
        take && ready && !redirect |=> !ready && ir_word == $past(ext_word));

    // R5
    idle_take_chk: assert property (@(posedge clk) disable iff (rst)
        take && !ready && !redirect && !mem_ack |=> $stable(ir_word) && !ready);

    // R6
    redirect_load_chk: assert property (@(posedge clk) disable iff (rst)
        redirect |=> !ready && mem_addr == $past(redirect_addr));

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack && !redirect |=> mem_req && $stable(mem_addr));

    // R10
    full_no_req_chk: assert property (@(posedge clk) disable iff (rst)
        ready |-> !mem_req);
endmodule

bind prefetch_queue pfq_checker #(.AW(AW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .mem_req       (mem_req),
    .mem_addr      (mem_addr),
    .mem_ack       (mem_ack),
    .take          (take),
    .redirect      (redirect),
    .redirect_addr (redirect_addr),
    .ready         (ready),
    .ir_word       (ir_word),
    .ext_word      (ext_word)
);

// File: tb/prefetch_queue_test.sv
`timescale 1ns/1ps
module prefetch_queue_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        take = 1'b0;
    logic        redirect = 1'b0;
    logic [15:0] redirect_addr = '0;
    logic        ready;
    logic [15:0] ir_word;
    logic [15:0] ext_word;

    int checks = 0;
    int fails = 0;
    int lat = 1;
    int wcnt = 0;
    int cycles = 0;
    logic [15:0] mem [256];
    logic [15:0] pc;

    prefetch_queue uut (.*);

    always #10 clk = ~clk;

    // memory model: ack after lat idle cycles, one word per request
    always @(negedge clk) begin
        if (rst || !mem_req || mem_ack) begin
            mem_ack = 1'b0;
            wcnt = 0;
        end else if (wcnt >= lat) begin
            mem_ack = 1'b1;
            mem_rdata = mem[mem_addr[8:1]];
        end else begin
            wcnt++;
        end
    end

    function automatic logic [15:0] mw(input logic [15:0] a);
        return mem[a[8:1]];
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_ready(input string req);
        for (int i = 0; i < 100 && !ready; i++) step();
        check(req, 16'(ready), 16'd1);
    endtask

    task automatic pulse_take();
        take = 1'b1;
        @(posedge clk);
        #1 take = 1'b0;
    endtask

    task automatic t_reset();
        step();
        check("R1 ready", 16'(ready), 16'd0);
        check("R1 mem_req", 16'(mem_req), 16'd1);
        check("R1 mem_addr", mem_addr, 16'h0100);
        rst = 1'b0;
        step();
        check("R1 mem_addr after release", mem_addr, 16'h0100);
    endtask

    task automatic t_fill();
        wait_ready("R2 ready");
        pc = 16'h0100;
        check("R2 ir", ir_word, mw(pc));
        check("R2 ext", ext_word, mw(pc + 16'd2));
        check("R3 ptr", mem_addr, pc + 16'd4);
        check("R10 no req when full", 16'(mem_req), 16'd0);
    endtask

    task automatic t_consume(input int n);
        for (int k = 0; k < n; k++) begin
            pulse_take();
            step();
            check("R4 ready drop", 16'(ready), 16'd0);
            check("R4 shift", ir_word, mw(pc + 16'd2));
            check("R4 refill addr", mem_addr, pc + 16'd4);
            pc = pc + 16'd2;
            wait_ready("R4 refill");
            check("R4 new ext", ext_word, mw(pc + 16'd2));
            check("R3 ptr", mem_addr, pc + 16'd4);
        end
    endtask

    task automatic t_ignore();
        pulse_take();
        pc = pc + 16'd2;
        step();
        for (int i = 0; i < 6 && !ready; i++) begin
            pulse_take();
        end
        wait_ready("R5 ready");
        check("R5 ir kept", ir_word, mw(pc));
        check("R5 ext", ext_word, mw(pc + 16'd2));
    endtask

    task automatic t_redirect(input logic [15:0] tgt);
        redirect = 1'b1;
        redirect_addr = tgt;
        @(posedge clk);
        #1 redirect = 1'b0;
        step();
        check("R6 ready low", 16'(ready), 16'd0);
        check("R6 ptr load", mem_addr, tgt);
        pc = tgt;
        wait_ready("R6 ready");
        check("R6 ir", ir_word, mw(tgt));
        check("R6 ext", ext_word, mw(tgt + 16'd2));
    endtask

    task automatic t_race(input logic [15:0] tgt);
        pulse_take();
        for (int i = 0; i < 20 && !mem_ack; i++) step();
        check("R7 ack seen", 16'(mem_ack), 16'd1);
        t_redirect(tgt);
        check("R7 discard ir", ir_word, mw(tgt));
    endtask

    task automatic t_stale();
        logic [15:0] old_ext;
        old_ext = ext_word;
        mem[(pc + 16'd2) >> 1] = 16'hDEAD;
        mem[(pc + 16'd4) >> 1] = 16'hBEEF;
        pulse_take();
        pc = pc + 16'd2;
        wait_ready("R8 ready");
        check("R8 held word kept", ir_word, old_ext);
        check("R8 later fetch sees write", ext_word, 16'hBEEF);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = {8'(i) ^ 8'h3C, 8'(i)};
        t_reset();
        t_fill();
        t_consume(3);
        t_ignore();
        t_redirect(16'h0040);
        lat = 0;
        t_consume(4);
        lat = 2;
        t_race(16'h0080);
        t_stale();
        lat = 3;
        t_redirect(16'h01F0);
        t_consume(2);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                checks++;
                fails++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                $display("%0d/%0d checks passed", checks - fails, checks);
                $finish;
            end
        end
    end
endmodule